// File: doc/BRIEF.md
# General-Purpose Event Register Bank

This block holds a small bank of byte-wide event registers behind a simple byte-addressed access port. The bank is `BANK_LEN` bytes long. The lower half of the address range holds status bytes and the upper half holds the enable bytes that pair with them. Software clears a status bit by writing a 1 to it. It sets or clears enable bits by overwriting the whole enable byte.

Hardware event sources drive a bit vector that is ORed into status byte 0. The block raises a level output whenever a status bit in byte 0 is set and its enable bit in byte 0 is also set. That level feeds the interrupt logic of the chip. An access to an address outside the bank has no effect on the bank, and the block pulses an error flag for it.

Top module: `gpe_bank`

## Requirements
- R1: With H = BANK_LEN/2, addresses 0 to H-1 select status bytes 0 to H-1, and address H+i selects the enable byte that pairs with status byte i.
- R2: A write to a status byte clears each bit whose write-data bit is 1 and leaves every other bit of that byte unchanged.
- R3: A write to an enable byte replaces the whole byte with the write data.
- R4: An access at an address of BANK_LEN or above reads 0 and changes no byte of the bank. `addr_err` is high for exactly the one cycle that follows that access's clock edge.
- R5: At the clock edge, every bit set in `evt_set` is ORed into status byte 0. `evt_irq` reflects the new state in the cycle after that edge.
- R6: `evt_irq` is high exactly when (status byte 0 AND enable byte 0) is non-zero. Status bytes above 0 receive no hardware events, and enable bytes above 0 never affect `evt_irq`.
- R7: Reset clears every status and enable byte and drives `evt_irq` and `addr_err` low.
- R8: `acc_rdata` presents the byte selected by `acc_addr` combinationally. A read changes no state, so reading a status byte does not clear it.
- R9: If, in the same cycle, an event sets a status bit in byte 0 and a write clears that same bit, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_write | input | 1 | 1 = write, 0 = read (qualified by acc_valid) |
| acc_addr | input | $clog2(BANK_LEN)+1 | Byte address |
| acc_wdata | input | DATA_W | Write data |
| acc_rdata | output | DATA_W | Read data for acc_addr |
| evt_set | input | DATA_W | Hardware event bits ORed into status byte 0 |
| evt_irq | output | 1 | Level: any enabled status bit of byte 0 is set |
| addr_err | output | 1 | One-cycle pulse after an access to an illegal address |

## Verification
The bench targets an event and a clearing write that land on the same status bit in the same cycle. A design that let the clear win would lose the event and leave `evt_irq` low. It writes enable bytes above 0 and checks that `evt_irq` ignores them, which catches a reduction over the whole bank instead of byte 0. It reads status bytes twice and checks the value survives, which catches a clear-on-read. Writes to addresses at and just past `BANK_LEN` must leave a full readback unchanged and raise `addr_err` for one cycle. A design that folded the address would corrupt a real byte instead.

// File: rtl/gpe_bank.sv
module gpe_bank #(
  parameter int BANK_LEN = 8,
  parameter int DATA_W   = 8,
  localparam int HALF    = BANK_LEN / 2,
  localparam int AW      = $clog2(BANK_LEN) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  input  logic              acc_write,
  input  logic [AW-1:0]     acc_addr,
  input  logic [DATA_W-1:0] acc_wdata,
  output logic [DATA_W-1:0] acc_rdata,
  input  logic [DATA_W-1:0] evt_set,
  output logic              evt_irq,
  output logic              addr_err
);

  logic [DATA_W-1:0] sts_q [HALF];
  logic [DATA_W-1:0] en_q  [HALF];

  wire legal = acc_addr < AW'(BANK_LEN);
  wire wr    = acc_valid && acc_write && legal;

  genvar g;
  generate
    for (g = 0; g < HALF; g++) begin : g_byte
      wire hit_s = wr && (acc_addr == AW'(g));
      wire hit_e = wr && (acc_addr == AW'(HALF + g));
      logic [DATA_W-1:0] sts_keep;
      assign sts_keep = hit_s ? (sts_q[g] & ~acc_wdata) : sts_q[g];

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          sts_q[g] <= '0;
          en_q[g]  <= '0;
        end else begin
          if (g == 0) sts_q[g] <= sts_keep | evt_set;
          else        sts_q[g] <= sts_keep;
          if (hit_e) en_q[g] <= acc_wdata;
        end
      end
    end
  endgenerate

  always_comb begin
    acc_rdata = '0;
    for (int i = 0; i < HALF; i++) begin
      if (acc_addr == AW'(i))        acc_rdata = sts_q[i];
      if (acc_addr == AW'(HALF + i)) acc_rdata = en_q[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) addr_err <= 1'b0;
    else        addr_err <= acc_valid && !legal;
  end

  assign evt_irq = |(sts_q[0] & en_q[0]);

endmodule

// File: rtl/gpe_bank_chk.sv
module gpe_bank_chk #(
  parameter int BANK_LEN = 8,
  parameter int DATA_W   = 8,
  localparam int HALF    = BANK_LEN / 2,
  localparam int AW      = $clog2(BANK_LEN) + 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              acc_valid,
  input logic              acc_write,
  input logic [AW-1:0]     acc_addr,
  input logic [DATA_W-1:0] acc_wdata,
  input logic [DATA_W-1:0] acc_rdata,
  input logic [DATA_W-1:0] evt_set,
  input logic              evt_irq,
  input logic              addr_err,
  input logic [DATA_W-1:0] sts0,
  input logic [DATA_W-1:0] en0
);

  wire bad = acc_valid && (acc_addr >= AW'(BANK_LEN));

  AST_CLEAR_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_write && acc_addr == '0) |=> ((sts0 & $past(acc_wdata) & ~$past(evt_set)) == '0)); // R2

  AST_ENABLE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_write && acc_addr == AW'(HALF)) |=> (en0 == $past(acc_wdata))); // R3

  AST_BAD_ADDR_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    bad |=> addr_err); // R4

  AST_NO_STRAY_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    !bad |=> !addr_err); // R4

  AST_BAD_ADDR_READ: assert property (@(posedge clk) disable iff (!rst_n)
    bad |-> (acc_rdata == '0)); // R4

  AST_BAD_WRITE_INERT: assert property (@(posedge clk) disable iff (!rst_n)
    (bad && acc_write && evt_set == '0) |=> ($stable(sts0) && $stable(en0))); // R4

  AST_EVENT_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_set != '0) |=> ((sts0 & $past(evt_set)) == $past(evt_set))); // R9

  AST_IRQ_FOLLOWS_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    ((evt_set & en0) != '0 && !(acc_valid && acc_write)) |=> evt_irq); // R5

  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    ((sts0 & en0) == '0) |-> !evt_irq); // R6

endmodule

bind gpe_bank gpe_bank_chk #(.BANK_LEN(BANK_LEN), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
  .acc_addr(acc_addr), .acc_wdata(acc_wdata), .acc_rdata(acc_rdata),
  .evt_set(evt_set), .evt_irq(evt_irq), .addr_err(addr_err),
  .sts0(sts_q[0]), .en0(en_q[0])
);

// File: tb/sim_gpe_bank.sv
`timescale 1ns/1ps
module sim_gpe_bank;
  localparam int LEN  = 8;
  localparam int DW   = 8;
  localparam int HALF = LEN / 2;
  localparam int AW   = $clog2(LEN) + 1;

  logic clk = 0, rst_n = 0;
  logic acc_valid = 0, acc_write = 0;
  logic [AW-1:0] acc_addr = '0;
  logic [DW-1:0] acc_wdata = '0, evt_set = '0;
  logic [DW-1:0] acc_rdata;
  logic evt_irq, addr_err;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [DW-1:0] m_sts [HALF];
  logic [DW-1:0] m_en  [HALF];

  always #5 clk = ~clk;

  gpe_bank #(.BANK_LEN(LEN), .DATA_W(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
    .acc_addr(acc_addr), .acc_wdata(acc_wdata), .acc_rdata(acc_rdata),
    .evt_set(evt_set), .evt_irq(evt_irq), .addr_err(addr_err));

  function automatic logic [DW-1:0] m_read(input int a);
    if (a < HALF) return m_sts[a];
    if (a < LEN)  return m_en[a - HALF];
    return '0;
  endfunction

  function automatic logic m_irq();
    return |(m_sts[0] & m_en[0]);
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one access cycle; inputs applied at negedge, results sampled at next negedge
  task automatic cyc(input bit v, input bit w, input int a, input logic [DW-1:0] d,
                     input logic [DW-1:0] ev, input string req);
    acc_valid = v; acc_write = w; acc_addr = AW'(a); acc_wdata = d; evt_set = ev;
    #1;
    if (v && !w) chk(acc_rdata === m_read(a), req, acc_rdata, m_read(a));
    @(posedge clk);
    if (v && w && a < HALF) m_sts[a] = m_sts[a] & ~d;
    if (v && w && a >= HALF && a < LEN) m_en[a - HALF] = d;
    m_sts[0] = m_sts[0] | ev;
    @(negedge clk);
    chk(addr_err === (v && a >= LEN), "R4 addr_err", addr_err, (v && a >= LEN));
    chk(evt_irq === m_irq(), req, evt_irq, m_irq());
    acc_valid = 0; acc_write = 0; evt_set = '0;
  endtask

  task automatic sweep(input string req);
    for (int a = 0; a < LEN + 2; a++) cyc(1, 0, a, '0, '0, req);
  endtask

  initial begin
    for (int i = 0; i < HALF; i++) begin m_sts[i] = '0; m_en[i] = '0; end
    void'($urandom(32'h5eed_0001));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(evt_irq === 1'b0, "R7 irq after reset", evt_irq, 0);
    chk(addr_err === 1'b0, "R7 err after reset", addr_err, 0);
    sweep("R7 reset readback");

    cyc(1, 1, HALF, 8'hFF, '0, "R3 enable write");
    cyc(0, 0, 0, '0, 8'h01, "R5 event raises irq");
    chk(evt_irq === 1'b1, "R5 irq set", evt_irq, 1);
    cyc(1, 0, 0, '0, '0, "R8 read status");
    cyc(1, 0, 0, '0, '0, "R8 second read keeps value");
    cyc(0, 0, 0, '0, 8'hA4, "R5 more events");
    cyc(1, 1, 0, 8'h05, '0, "R2 partial clear");
    cyc(1, 0, 0, '0, '0, "R2 readback");
    cyc(1, 1, 0, 8'h08, 8'h08, "R9 event beats clear");
    cyc(1, 0, 0, '0, '0, "R9 readback");
    cyc(1, 1, HALF, 8'h00, '0, "R6 disable byte0");
    chk(evt_irq === 1'b0, "R6 irq low with en0=0", evt_irq, 0);
    cyc(1, 1, HALF + 1, 8'hFF, '0, "R6 enable byte1");
    cyc(1, 1, HALF + 2, 8'h3C, '0, "R1 enable byte2");
    cyc(1, 0, 2, '0, '0, "R1 status byte2 stays 0");
    cyc(1, 0, HALF + 2, '0, '0, "R1 enable byte2 readback");
    chk(evt_irq === 1'b0, "R6 upper enables ignored", evt_irq, 0);
    cyc(1, 1, LEN, 8'hFF, '0, "R4 write at LEN");
    cyc(1, 1, LEN + 1, 8'h00, '0, "R4 write past LEN");
    cyc(1, 1, (1 << AW) - 1, 8'h00, '0, "R4 write top addr");
    sweep("R4 bank unchanged");

    for (int n = 0; n < 3000; n++) begin
      int a;
      bit v, w;
      logic [DW-1:0] d, ev;
      v  = ($urandom % 4) != 0;
      w  = $urandom % 2;
      a  = $urandom_range(0, (1 << AW) - 1);
      if (($urandom % 3) != 0) a = a % LEN;
      d  = DW'($urandom);
      ev = (($urandom % 4) == 0) ? DW'($urandom) : '0;
      cyc(v, w, a, d, ev, "R2 R3 R5 random");
    end
    sweep("R1 final readback");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL R7 watchdog actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule